// File: doc/BRIEF.md
# Two-Core MOESI Coherence Controller

This block is a cycle-level model of snooping coherence between two processors that share a small memory. Each processor has a one-line, direct-mapped, write-back, write-allocate cache. Every line carries one of five coherence states (Modified, Owned, Exclusive, Shared, Invalid) and the tag of the block it holds. For every memory block the controller also tracks whether memory holds the latest copy.

Each cycle the controller can take one request. A request names the core, says whether it is a read or a write, and gives the block address. The controller applies the snoop result at once: a write invalidates the other cache's copy of that block. A read that finds a copy in the other cache makes that holder Owned and does not write the data back. Replacing a line that holds dirty data writes the old block back to memory. The new state and tag of both lines, and the up-to-date flag of every memory block, are available from the cycle after the request.

Top module: `moesi_pair_ctrl`

## Requirements
- R1: After reset both lines are Invalid with tag 0 and every memory block is flagged up to date. States are encoded as Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. A request with `reqValid` high is applied at the rising edge that samples it, and the outputs show the result from that edge on.
- R2: A read from a core whose line does not hold the block, when the other line does not hold it either, installs the block in the requester as Exclusive with the requested tag.
- R3: A read miss when the other line holds the block in Exclusive, Owned or Modified makes the requester Shared and the other line Owned, and leaves that block's up-to-date flag unchanged. If the other line holds the block in Shared, both lines end Shared.
- R4: A read that hits in the requester's own line (state not Invalid and tag equal) changes no state, tag or memory flag.
- R5: A write leaves the requester Modified with the requested tag and flags that memory block not up to date. If the other line holds the same block, that line becomes Invalid. This applies to a write that hits in Exclusive, Shared or Owned and to a write miss.
- R6: A write that hits a Modified line changes nothing.
- R7: On a miss, a requester line in Modified or Owned that held a different block writes it back, so that the old block is flagged up to date. A replaced line in Shared or Exclusive changes no memory flag.
- R8: In a cycle with `reqValid` low, no state, tag or memory flag changes.
- R9: A line in Modified always has its block flagged not up to date, and a line in Exclusive always has its block flagged up to date. No block is held in Modified or Exclusive by one line while the other line holds it in a valid state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqCore | input | 1 | Requesting core: 0 or 1 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (1) | Block address |
| stateCore0 | output | 3 | Coherence state of core 0's line |
| stateCore1 | output | 3 | Coherence state of core 1's line |
| tagCore0 | output | ADDR_W (1) | Block held by core 0's line |
| tagCore1 | output | ADDR_W (1) | Block held by core 1's line |
| memUpToDate | output | MEM_BLOCKS (2) | One flag per block, 1 = memory holds latest copy |

## Verification
Every result of a request, including the writer's state, the snooped line's state and the victim's write-back flag, comes from a single register stage. All of them are due at the rising edge that samples the request. The bench drives each request on a falling edge and compares all outputs on the next falling edge, halfway through the cycle after the update. That cycle is the same one in which the next request is presented. An idle cycle is checked the same way, with the outputs expected to be unchanged one edge later.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  parameter int unsigned MEM_BLOCKS = 2;
  localparam int unsigned ADDR_W = (MEM_BLOCKS > 1) ? $clog2(MEM_BLOCKS) : 1;
  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned CORE_W = 1;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } lineState_e;

  // strobes from control to datapath for one request
  typedef struct packed {
    logic [NUM_CORES-1:0]              lineWe;
    lineState_e [NUM_CORES-1:0]        nextState;
    logic [NUM_CORES-1:0]              tagWe;
    logic [ADDR_W-1:0]                 newTag;
    logic                              cleanWe;
    logic [ADDR_W-1:0]                 cleanAddr;
    logic                              dirtyWe;
    logic [ADDR_W-1:0]                 dirtyAddr;
  } strobe_t;

endpackage

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
(
  input  logic                                reqValid,
  input  logic [CORE_W-1:0]                   reqCore,
  input  logic                                reqWrite,
  input  logic [ADDR_W-1:0]                   reqAddr,
  input  lineState_e [NUM_CORES-1:0]          curState,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]    curTag,
  output strobe_t                             stb
);

  logic [CORE_W-1:0] me;
  logic [CORE_W-1:0] ot;
  logic meHit;
  logic otHit;
  logic victimDirty;
  logic otSupplies;

  assign me = reqCore;
  assign ot = reqCore ^ 1'b1;

  assign meHit = (curState[me] != ST_I) && (curTag[me] == reqAddr);
  assign otHit = (curState[ot] != ST_I) && (curTag[ot] == reqAddr);
  assign victimDirty = !meHit && ((curState[me] == ST_M) || (curState[me] == ST_O));
  assign otSupplies = otHit && (curState[ot] != ST_S);

  always_comb begin
    stb = '0;
    stb.nextState = curState;
    stb.newTag = reqAddr;
    stb.dirtyAddr = reqAddr;
    stb.cleanAddr = curTag[me];
    if (reqValid) begin
      // replacement of a dirty line writes the old block back
      stb.cleanWe = victimDirty;
      if (!reqWrite) begin
        if (!meHit) begin
          stb.lineWe[me] = 1'b1;
          stb.tagWe[me] = 1'b1;
          if (otHit) begin
            stb.nextState[me] = ST_S;
            if (otSupplies) begin
              stb.lineWe[ot] = 1'b1;
              stb.nextState[ot] = ST_O;
            end
          end else begin
            stb.nextState[me] = ST_E;
          end
        end
      end else begin
        if (!(meHit && (curState[me] == ST_M))) begin
          stb.lineWe[me] = 1'b1;
          stb.nextState[me] = ST_M;
          stb.tagWe[me] = !meHit;
          stb.dirtyWe = 1'b1;
        end
        if (otHit) begin
          stb.lineWe[ot] = 1'b1;
          stb.nextState[ot] = ST_I;
        end
      end
    end
  end

endmodule

// File: rtl/moesi_dp.sv
module moesi_dp
  import moesi_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             stb,
  output lineState_e [NUM_CORES-1:0]          curState,
  output logic [NUM_CORES-1:0][ADDR_W-1:0]    curTag,
  output logic [MEM_BLOCKS-1:0]               memClean
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_line
    lineState_e stReg;
    logic [ADDR_W-1:0] tagReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stReg <= ST_I;
        tagReg <= '0;
      end else begin
        if (stb.lineWe[c]) stReg <= stb.nextState[c];
        if (stb.tagWe[c]) tagReg <= stb.newTag;
      end
    end

    assign curState[c] = stReg;
    assign curTag[c] = tagReg;
  end

  for (genvar b = 0; b < MEM_BLOCKS; b++) begin : g_mem
    logic cleanReg;
    logic hitClean;
    logic hitDirty;

    assign hitClean = stb.cleanWe && (stb.cleanAddr == ADDR_W'(b));
    assign hitDirty = stb.dirtyWe && (stb.dirtyAddr == ADDR_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cleanReg <= 1'b1;
      end else if (hitDirty) begin
        cleanReg <= 1'b0;
      end else if (hitClean) begin
        cleanReg <= 1'b1;
      end
    end

    assign memClean[b] = cleanReg;
  end

endmodule

// File: rtl/moesi_pair_ctrl.sv
module moesi_pair_ctrl
  import moesi_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqCore,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  output logic [STATE_W-1:0]        stateCore0,
  output logic [STATE_W-1:0]        stateCore1,
  output logic [ADDR_W-1:0]         tagCore0,
  output logic [ADDR_W-1:0]         tagCore1,
  output logic [MEM_BLOCKS-1:0]     memUpToDate
);

  strobe_t stb;
  lineState_e [NUM_CORES-1:0] curState;
  logic [NUM_CORES-1:0][ADDR_W-1:0] curTag;

  moesi_ctrl i_ctrl (
    .reqValid (reqValid),
    .reqCore  (reqCore),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .curState (curState),
    .curTag   (curTag),
    .stb      (stb)
  );

  moesi_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .curState (curState),
    .curTag   (curTag),
    .memClean (memUpToDate)
  );

  assign stateCore0 = curState[0];
  assign stateCore1 = curState[1];
  assign tagCore0 = curTag[0];
  assign tagCore1 = curTag[1];

endmodule

// File: rtl/moesi_pair_chk.sv
module moesi_pair_chk
  import moesi_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqCore,
  input logic                   reqWrite,
  input logic [ADDR_W-1:0]      reqAddr,
  input logic [STATE_W-1:0]     stateCore0,
  input logic [STATE_W-1:0]     stateCore1,
  input logic [ADDR_W-1:0]      tagCore0,
  input logic [ADDR_W-1:0]      tagCore1,
  input logic [MEM_BLOCKS-1:0]  memUpToDate
);

  logic [STATE_W-1:0] reqSt;
  logic [STATE_W-1:0] othSt;
  logic [ADDR_W-1:0]  reqTg;
  logic [ADDR_W-1:0]  othTg;
  logic reqMiss;
  logic othSupplies;

  assign reqSt = reqCore ? stateCore1 : stateCore0;
  assign othSt = reqCore ? stateCore0 : stateCore1;
  assign reqTg = reqCore ? tagCore1 : tagCore0;
  assign othTg = reqCore ? tagCore0 : tagCore1;
  assign reqMiss = (reqSt == 3'd0) || (reqTg != reqAddr);
  assign othSupplies = (othTg == reqAddr) &&
                       ((othSt == 3'd2) || (othSt == 3'd3) || (othSt == 3'd4));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable({stateCore0, stateCore1, tagCore0, tagCore1, memUpToDate}));

  // R5
  write_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=>
      ((($past(reqCore) ? stateCore1 : stateCore0) == 3'd4) &&
       !memUpToDate[$past(reqAddr)]));

  // R5
  write_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=>
      ((($past(reqCore) ? stateCore0 : stateCore1) == 3'd0) ||
       (($past(reqCore) ? tagCore0 : tagCore1) != $past(reqAddr))));

  // R3
  read_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqMiss && othSupplies) |=>
      ((($past(reqCore) ? stateCore0 : stateCore1) == 3'd3) &&
       (($past(reqCore) ? stateCore1 : stateCore0) == 3'd1)));

  // R9
  mod_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCore0 != 3'd4) || !memUpToDate[tagCore0]) &&
    ((stateCore1 != 3'd4) || !memUpToDate[tagCore1]));

  // R9
  excl_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCore0 != 3'd2) || memUpToDate[tagCore0]) &&
    ((stateCore1 != 3'd2) || memUpToDate[tagCore1]));

  // R9
  sole_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stateCore0 == 3'd4 || stateCore0 == 3'd2) && stateCore1 != 3'd0) |->
      (tagCore0 != tagCore1));

endmodule

bind moesi_pair_ctrl moesi_pair_chk i_moesi_pair_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqCore     (reqCore),
  .reqWrite    (reqWrite),
  .reqAddr     (reqAddr),
  .stateCore0  (stateCore0),
  .stateCore1  (stateCore1),
  .tagCore0    (tagCore0),
  .tagCore1    (tagCore1),
  .memUpToDate (memUpToDate)
);

// File: tb/test_moesi_pair_ctrl.sv
`timescale 1ns/1ps
module test_moesi_pair_ctrl;
  import moesi_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqCore = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [STATE_W-1:0] stateCore0, stateCore1;
  logic [ADDR_W-1:0] tagCore0, tagCore1;
  logic [MEM_BLOCKS-1:0] memUpToDate;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the requirements
  int mSt [2];
  int mTg [2];
  bit mCl [2];

  always #10 clk = ~clk;

  moesi_pair_ctrl i_moesi_pair_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCore(reqCore),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .stateCore0(stateCore0),
    .stateCore1(stateCore1), .tagCore0(tagCore0), .tagCore1(tagCore1),
    .memUpToDate(memUpToDate)
  );

  function automatic int dutVec();
    return (int'(stateCore0) << 8) | (int'(stateCore1) << 4) |
           (int'(tagCore0) << 3) | (int'(tagCore1) << 2) | int'(memUpToDate);
  endfunction

  function automatic int modelVec();
    return (mSt[0] << 8) | (mSt[1] << 4) | (mTg[0] << 3) | (mTg[1] << 2) |
           (int'(mCl[1]) << 1) | int'(mCl[0]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin mSt[c] = 0; mTg[c] = 0; mCl[c] = 1'b1; end
  endtask

  // R2..R8 applied to the bench model
  task automatic modelStep(input bit v, input int c, input bit w, input int a,
                           output string tag);
    int o;
    bit meHit, otHit, evict;
    o = 1 - c;
    meHit = (mSt[c] != 0) && (mTg[c] == a);
    otHit = (mSt[o] != 0) && (mTg[o] == a);
    evict = 1'b0;
    if (!v) begin tag = "R8"; return; end
    if (!meHit && mSt[c] != 0) begin
      evict = 1'b1;
      if (mSt[c] == 4 || mSt[c] == 3) mCl[mTg[c]] = 1'b1;
    end
    if (!w) begin
      if (meHit) tag = "R4";
      else if (otHit) begin
        tag = "R3";
        if (mSt[o] != 1) mSt[o] = 3;
        mSt[c] = 1; mTg[c] = a;
      end else begin
        tag = "R2";
        mSt[c] = 2; mTg[c] = a;
      end
    end else if (meHit && mSt[c] == 4) begin
      tag = "R6";
    end else begin
      tag = "R5";
      mSt[c] = 4; mTg[c] = a; mCl[a] = 1'b0;
      if (otHit) mSt[o] = 0;
    end
    if (evict) tag = {tag, "/R7"};
  endtask

  // called on a falling edge; compares on the next falling edge
  task automatic doReq(input bit v, input int c, input bit w, input int a,
                       output string tag);
    reqValid = v; reqCore = c[0]; reqWrite = w; reqAddr = ADDR_W'(a);
    modelStep(v, c, w, a, tag);
    @(negedge clk);
    check(tag, dutVec(), modelVec());
  endtask

  // ten-step trace: core, write, addr and expected states / flags
  int trC [10] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 0};
  int trW [10] = '{0, 0, 1, 1, 0, 0, 1, 0, 1, 0};
  int trA [10] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 0};
  int exS0 [10] = '{2, 3, 4, 0, 2, 3, 4, 3, 0, 1};
  int exS1 [10] = '{0, 1, 0, 4, 4, 1, 0, 1, 4, 3};
  int exM0 [10] = '{1, 1, 1, 1, 1, 1, 0, 0, 0, 0};
  int exM1 [10] = '{1, 1, 0, 0, 0, 1, 1, 1, 1, 1};

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    bit [15:0] lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state (I=0, tags 0, all blocks up to date)
    check("R1", dutVec(), 32'h003);

    // trace replay
    for (int i = 0; i < 10; i++) begin
      doReq(1'b1, trC[i], trW[i][0], trA[i], tag);
      check({"trace ", tag},
            (int'(stateCore0) << 8) | (int'(stateCore1) << 4) | int'(memUpToDate),
            (exS0[i] << 8) | (exS1[i] << 4) | (exM1[i] << 1) | exM0[i]);
    end

    // R8: idle cycle holds everything
    doReq(1'b0, 0, 1'b1, 1, tag);

    // R6: repeated write to a Modified line (core1 is Owned of 0 here; write makes it M, then again)
    doReq(1'b1, 1, 1'b1, 0, tag);
    doReq(1'b1, 1, 1'b1, 0, tag);
    // R7: evicting Modified writes back
    doReq(1'b1, 1, 1'b0, 1, tag);
    check("R7 block0 written back", int'(memUpToDate[0]), 1);

    // R1 again after a fresh reset, then sweep all request patterns
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    check("R1", dutVec(), 32'h003);
    lfsr = 16'hACE1;
    for (int k = 0; k < 800; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doReq(lfsr[3:0] != 4'd0, int'(lfsr[5]), lfsr[7], int'(lfsr[9]), tag);
    end
    // all 16 combinations from every reached state once more in order
    for (int k = 0; k < 64; k++)
      doReq(k[5:4] != 2'd0, k[0], k[1], k[2], tag);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule